// File: doc/BRIEF.md
# Overload Fault Timer and Latch

This block supervises overload faults for a fixed-frequency PWM controller. A current-sense comparator bit tells it that the sensed current has reached its 1 V ceiling. A period tick marks each switching period. Two clear inputs complete the interface: a brown-out reset/shutdown level and a supply-undervoltage level. The block's output is the gate-drive enable. When an overload is seen, the block records a fault and starts a timeout counter that runs on the system clock.

The timeout is 15 ms at the default clock. If the fault record is still present when the timeout expires, the fault latches and the drive enable stays low until one of the clear inputs is asserted. When an overload disappears, the timer does not clear at once. It clears only after three back-to-back switching periods in which the comparator never fired.

While a clear input is high it overrides everything else: it blanks the drive and wipes all state. When it is released, the block is idle and drive is enabled.

Top module: `ovl_fault_supervisor`

## Requirements
- R1: After rst_ni is released, drv_en_o is 1, timer_run_o is 0 and fault_latched_o is 0.
- R2: From idle, with no clear input high, ovl_i = 1 at a clock edge sets timer_run_o = 1 after that edge.
- R3: If the fault record is captured at edge k and is not cleared, then fault_latched_o becomes 1 and drv_en_o and timer_run_o become 0 after edge k + TIMEOUT_CYC.
- R4: Once fault_latched_o is 1, it stays 1 and drv_en_o stays 0 whatever ovl_i and period_tick_i do, as long as neither clear input is high.
- R5: Removing the overload, or applying it again, while the timer runs neither stops nor restarts the count. Expiry still falls on edge k + TIMEOUT_CYC.
- R6: A period is the set of cycles after one period_tick_i cycle, up to and including the next one. While the timer runs, timer_run_o falls after the edge that ends the third consecutive period in which ovl_i was never 1 (CLEAN_PERIODS = 3).
- R7: A period that contains ovl_i = 1, including ovl_i = 1 in the tick cycle itself, sets the clean-period count back to zero.
- R8: bo_shdn_i = 1 clears the latch, the timer and the clean-period count at the next edge. When bo_shdn_i returns to 0, the block is idle with drv_en_o = 1.
- R9: uvlo_i = 1 has the same clearing effect as bo_shdn_i.
- R10: In any cycle where a clear input is high, ovl_i is not captured.
- R11: If the timer expires on the same edge that completes the third clean period, the fault latches.
- R12: drv_en_o is 0 in the same cycle in which bo_shdn_i or uvlo_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovl_i | input | 1 | Current-sense overload comparator bit |
| period_tick_i | input | 1 | One-cycle pulse at the end of each switching period |
| bo_shdn_i | input | 1 | Brown-out reset / shutdown level, active high |
| uvlo_i | input | 1 | Supply below turn-off threshold, active high |
| drv_en_o | output | 1 | Gate-drive enable |
| timer_run_o | output | 1 | Fault timer is counting |
| fault_latched_o | output | 1 | Fault has latched |

## Verification
Two events can fall on the same edge: the timeout expiring and the third clean period being completed. The bench provokes this by capturing a one-cycle overload at a known edge k and then placing three single-cycle ticks so that the last one lands on edge k + TIMEOUT_CYC. The result is judged correct if the latch is set and the drive is low. A control run shifts the ticks one edge earlier, and there the timer must clear and the latch must never appear. The same-cycle collision of a clear input with an overload is judged the same way: after release, the block must show no running timer.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TIMING = 2'd1,
    ST_LATCH  = 2'd2
  } ofs_state_e;
endpackage

// File: rtl/ofs_period_mon.sv
module ofs_period_mon #(
  parameter int unsigned CLEAN_PERIODS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic ovl_i,
  input  logic tick_i,
  output logic clean_done_o
);
  localparam int unsigned CW = $clog2(CLEAN_PERIODS + 1);
  localparam logic [CW-1:0] LAST = CW'(CLEAN_PERIODS - 1);

  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic          faulty;

  // overload in the tick cycle belongs to the period that ends there
  assign faulty       = seen_q | ovl_i;
  assign clean_done_o = arm_i & tick_i & ~faulty & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (clr_i)   seen_q <= 1'b0;
    else if (tick_i)  seen_q <= 1'b0;
    else if (ovl_i)   seen_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !arm_i)  cnt_q <= '0;
    else if (tick_i) begin
      if (faulty)              cnt_q <= '0;
      else if (clean_done_o)   cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ofs_timeout.sv
module ofs_timeout #(
  parameter int unsigned TIMEOUT_CYC = 3_750_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !run_i)  cnt_q <= '0;
    else if (cnt_q != LAST)    cnt_q <= cnt_q + 1'b1;  // saturate at expiry
  end
endmodule

// File: rtl/ofs_fault_fsm.sv
module ofs_fault_fsm
  import ofs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       ovl_i,
  input  logic       expire_i,
  input  logic       clean_done_i,
  output ofs_state_e state_o
);
  ofs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (ovl_i) state_d = ST_TIMING;
      ST_TIMING: begin
        if (expire_i)          state_d = ST_LATCH;  // expiry beats clean clear
        else if (clean_done_i) state_d = ST_IDLE;
      end
      ST_LATCH:  state_d = ST_LATCH;
      default:   state_d = ST_IDLE;
    endcase
    if (clr_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ovl_fault_supervisor.sv
module ovl_fault_supervisor
  import ofs_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC   = 3_750_000,
  parameter int unsigned CLEAN_PERIODS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovl_i,
  input  logic period_tick_i,
  input  logic bo_shdn_i,
  input  logic uvlo_i,
  output logic drv_en_o,
  output logic timer_run_o,
  output logic fault_latched_o
);
  logic       clr;
  logic       run;
  logic       expire;
  logic       clean_done;
  ofs_state_e state;

  assign clr = bo_shdn_i | uvlo_i;
  assign run = (state == ST_TIMING);

  ofs_fault_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .ovl_i        (ovl_i),
    .expire_i     (expire),
    .clean_done_i (clean_done),
    .state_o      (state)
  );

  ofs_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .run_i    (run),
    .expire_o (expire)
  );

  ofs_period_mon #(.CLEAN_PERIODS(CLEAN_PERIODS)) u_pmon (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .arm_i        (run),
    .ovl_i        (ovl_i),
    .tick_i       (period_tick_i),
    .clean_done_o (clean_done)
  );

  assign timer_run_o     = run;
  assign fault_latched_o = (state == ST_LATCH);
  assign drv_en_o        = ~(fault_latched_o | clr);
endmodule

// File: rtl/ofs_checker.sv
module ofs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ovl_i,
  input logic period_tick_i,
  input logic bo_shdn_i,
  input logic uvlo_i,
  input logic drv_en_o,
  input logic timer_run_o,
  input logic fault_latched_o
);
  logic clr;
  assign clr = bo_shdn_i | uvlo_i;

  assert_latch_blanks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_latched_o |-> !drv_en_o);

  assert_latch_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_latched_o && !clr) |=> fault_latched_o);

  assert_status_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(timer_run_o && fault_latched_o));

  assert_latch_after_timer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_latched_o) |-> $past(timer_run_o));

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_i && !clr && !timer_run_o && !fault_latched_o) |=> timer_run_o);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (!fault_latched_o && !timer_run_o));

  assert_clear_blanks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |-> !drv_en_o);

  assert_clean_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_run_o && !clr && !period_tick_i) |=> (timer_run_o || fault_latched_o));
endmodule

bind ovl_fault_supervisor ofs_checker u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ovl_i           (ovl_i),
  .period_tick_i   (period_tick_i),
  .bo_shdn_i       (bo_shdn_i),
  .uvlo_i          (uvlo_i),
  .drv_en_o        (drv_en_o),
  .timer_run_o     (timer_run_o),
  .fault_latched_o (fault_latched_o)
);

// File: tb/sim_ovl_fault_supervisor.sv
`timescale 1ns/1ps
module sim_ovl_fault_supervisor;
  localparam int unsigned T = 40;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ovl_i = 1'b0, period_tick_i = 1'b0, bo_shdn_i = 1'b0, uvlo_i = 1'b0;
  logic drv_en_o, timer_run_o, fault_latched_o;
  int total = 0, bad = 0;

  always #2 clk_i = ~clk_i;

  ovl_fault_supervisor #(.TIMEOUT_CYC(T), .CLEAN_PERIODS(3)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ovl_i(ovl_i), .period_tick_i(period_tick_i),
    .bo_shdn_i(bo_shdn_i), .uvlo_i(uvlo_i), .drv_en_o(drv_en_o),
    .timer_run_o(timer_run_o), .fault_latched_o(fault_latched_o)
  );

  task automatic step(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_clear();
    bo_shdn_i = 1'b1; step(); bo_shdn_i = 1'b0; step();
  endtask

  task automatic tick();
    period_tick_i = 1'b1; step(); period_tick_i = 1'b0;
  endtask

  task automatic capture();  // capture edge k is the edge of this step
    ovl_i = 1'b1; step(); ovl_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 drv", drv_en_o, 1'b1);
    chk("R1 run", timer_run_o, 1'b0);
    chk("R1 latch", fault_latched_o, 1'b0);
  endtask

  task automatic t_capture();
    capture();
    chk("R2 run", timer_run_o, 1'b1);
    do_clear();
    chk("R8 run cleared", timer_run_o, 1'b0);
  endtask

  task automatic t_expire();
    capture();                    // at k
    step(5);
    ovl_i = 1'b1; step(); ovl_i = 1'b0;   // reappears mid-count, k+6
    step(T - 7);                  // at k+T-1
    chk("R5 still running", timer_run_o, 1'b1);
    chk("R5 not latched early", fault_latched_o, 1'b0);
    step();                       // k+T
    chk("R3 latched", fault_latched_o, 1'b1);
    chk("R3 drv low", drv_en_o, 1'b0);
    chk("R3 run low", timer_run_o, 1'b0);
  endtask

  task automatic t_persist_and_bo();
    ovl_i = 1'b1; step(3); ovl_i = 1'b0;
    for (int i = 0; i < 5; i++) begin tick(); step(); end
    chk("R4 latch holds", fault_latched_o, 1'b1);
    chk("R4 drv held low", drv_en_o, 1'b0);
    bo_shdn_i = 1'b1; #1;
    chk("R12 drv low same cycle", drv_en_o, 1'b0);
    step();
    chk("R8 latch cleared", fault_latched_o, 1'b0);
    chk("R12 drv low while bo", drv_en_o, 1'b0);
    bo_shdn_i = 1'b0; #1;
    chk("R8 drv back", drv_en_o, 1'b1);
    step();
    chk("R8 idle", timer_run_o, 1'b0);
  endtask

  task automatic t_clean();
    capture(); step();
    tick(); step();       // faulty period (overload seen)
    tick(); step();       // clean 1
    tick();               // clean 2
    chk("R6 running after two clean", timer_run_o, 1'b1);
    step();
    tick();               // clean 3
    chk("R6 cleared after three clean", timer_run_o, 1'b0);
    chk("R6 drv on", drv_en_o, 1'b1);
  endtask

  task automatic t_recount();
    capture(); step();
    tick(); step();       // faulty
    tick(); step();       // clean 1
    tick(); step();       // clean 2
    ovl_i = 1'b1; period_tick_i = 1'b1; step();   // overload in tick cycle
    ovl_i = 1'b0; period_tick_i = 1'b0;
    chk("R7 running after faulty period", timer_run_o, 1'b1);
    step();
    tick(); step();       // clean 1
    tick(); step();       // clean 2
    chk("R7 count restarted", timer_run_o, 1'b1);
    tick();               // clean 3
    chk("R7 cleared after fresh three", timer_run_o, 1'b0);
  endtask

  task automatic t_uvlo();
    capture(); step(T);
    chk("R3 latched again", fault_latched_o, 1'b1);
    uvlo_i = 1'b1; ovl_i = 1'b1; step(4);
    chk("R9 latch cleared", fault_latched_o, 1'b0);
    chk("R10 no capture under uvlo", timer_run_o, 1'b0);
    uvlo_i = 1'b0; ovl_i = 1'b0; #1;
    chk("R9 drv back", drv_en_o, 1'b1);
  endtask

  task automatic t_prio();
    bo_shdn_i = 1'b1; ovl_i = 1'b1; step();
    bo_shdn_i = 1'b0; ovl_i = 1'b0; step();
    chk("R10 bo beats ovl", timer_run_o, 1'b0);
  endtask

  task automatic t_collide();
    capture();                       // k
    tick();                          // k+1, faulty
    step(T - 4);                     // k+T-3
    period_tick_i = 1'b1; step(3); period_tick_i = 1'b0;   // clean at k+T-2..k+T
    chk("R11 expiry wins latch", fault_latched_o, 1'b1);
    chk("R11 drv low", drv_en_o, 1'b0);
    do_clear();
    capture();                       // k
    tick();                          // k+1
    step(T - 5);                     // k+T-4
    period_tick_i = 1'b1; step(3); period_tick_i = 1'b0;   // clean ends at k+T-1
    chk("R11 control cleared", timer_run_o, 1'b0);
    step(5);
    chk("R11 control no latch", fault_latched_o, 1'b0);
    chk("R11 control drv on", drv_en_o, 1'b1);
  endtask

  initial begin
    step(3); rst_ni = 1'b1; step();
    t_reset();
    t_capture();
    t_expire();
    t_persist_and_bo();
    t_clean();
    t_recount();
    t_uvlo();
    t_prio();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule